// File: doc/BRIEF.md
# Nibble-Serial Sample Word Interface

This block sits between a signal processor and a converter core and moves 16-bit sample words across two 4-bit nibble buses, one per direction. From a single master clock it derives a nibble clock and a word strobe. The nibble clock runs at the master rate divided by a ratio of 1, 2, 4 or 8. The word strobe marks the first nibble slot of every sample. Transmit nibbles from the processor are gathered into one word and handed to the converter core with a single-cycle valid pulse. Each receive word from the core is taken at the start of a sample and sent out as four nibbles.

Each word travels as four nibble slots, least significant nibble first. Line k of the bus in slot n carries word bit 4n+k. The divider ratio, the transmit capture point and the receive launch point are set by configuration inputs. A change of ratio waits for the next word boundary, so no word is ever cut short. Two loopback controls feed the captured transmit word back into the receive serializer, or pass the core's receive word straight to the transmit word output.

Everything runs on the master clock. The nibble clock and word strobe are registered outputs. Each nibble slot lasts N master cycles, and "edges" of the nibble clock are cycle positions within a slot: the rising edge is the slot boundary, and the falling edge is the slot midpoint.

Top module: `nibble_word_if`

## Requirements
- R1: The transmit word is assembled with the nibble captured in slot n placed at bits 4n+3..4n, slot 0 being the slot in which the word strobe is high.
- R2: A received word is sent with bits 4n+3..4n on the receive bus in slot n, starting with slot 0 (word strobe high).
- R3: The divider code sets the nibble slot length N in master cycles: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8.
- R4: The word strobe repeats every 4N master cycles and stays high for exactly N cycles, covering slot 0.
- R5: A divider code change takes effect only at the next word boundary; the word in progress keeps its old length.
- R6: With transmit edge select 1, each transmit nibble is captured on the master edge that ends the slot. With select 0, it is captured on the edge that ends cycle N/2-1 of the slot, which is the last cycle when N is 1.
- R7: With receive edge select 0, the receive bus changes at the start of each slot. With select 1, it changes at cycle N/2 of the slot, which is cycle 0 when N is 1.
- R8: The transmit valid output is high for exactly one cycle, in the cycle right after the edge that captures nibble 3, together with the assembled word.
- R9: The receive word input is sampled only on the edge at which the word strobe rises; later changes within the sample have no effect on the nibbles sent.
- R10: With transmit-to-receive loopback set, the serializer loads the last assembled transmit word instead of the receive word input.
- R11: With receive-to-transmit loopback set, the transmit word output takes the receive word input at each word strobe rise, with a one-cycle valid pulse. Assembled transmit words are not posted in this mode.
- R12: Synchronous reset drives the word strobe, nibble clock, valid and receive bus low. The first word strobe rise comes exactly 4N master cycles after reset is released.
- R13: The nibble clock is high for the first N/2 cycles of each slot when N is at least 2, and stays high when N is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 2 | Divider code, 0..3 for N = 1, 2, 4, 8 |
| tx_rise_i | input | 1 | Transmit capture at slot end (1) or slot midpoint (0) |
| rx_rise_i | input | 1 | Receive launch at slot midpoint (1) or slot start (0) |
| lb_tx2rx_i | input | 1 | Loop assembled transmit words into the receive serializer |
| lb_rx2tx_i | input | 1 | Loop receive words into the transmit word output |
| tx_nib_i | input | 4 | Transmit nibble bus from the processor |
| rx_word_i | input | 16 | Receive word from the converter core |
| nib_clk_o | output | 1 | Nibble clock |
| word_clk_o | output | 1 | Word strobe, high during slot 0 |
| rx_nib_o | output | 4 | Receive nibble bus to the processor |
| tx_word_o | output | 16 | Assembled transmit word to the converter core |
| tx_vld_o | output | 1 | Single-cycle valid for tx_word_o |

## Verification
Every timing result is counted from the cycle in which the word strobe is first seen high, called slot cycle 0. An assembled transmit word is due 3N+c+1 cycles later, where c is the capture cycle within slot 3. The scoreboard stores that due cycle with each expected word and compares only in that cycle. Receive nibbles are sampled at cycle kN, or kN+N/2 in midpoint mode, and the cycle before the launch is also checked so that the two launch points can be told apart. Word periods are counted in cycles from one strobe rise to the next, and receive-to-transmit loopback words are checked in slot cycle 0 itself.

// File: rtl/nwi_pkg.sv
package nwi_pkg;

  typedef int unsigned nwi_uint_t;

  // nibble slot length in master cycles for a divider code
  function automatic nwi_uint_t nwi_ratio(input nwi_uint_t code);
    return nwi_uint_t'(1) << code;
  endfunction

  // midpoint cycle of a slot (0 when the slot is one cycle long)
  function automatic nwi_uint_t nwi_mid(input nwi_uint_t code);
    return (code == 0) ? 0 : (nwi_uint_t'(1) << (code - 1));
  endfunction

  // number of cycles the nibble clock stays high within a slot
  function automatic nwi_uint_t nwi_hi_len(input nwi_uint_t code);
    return (code == 0) ? 1 : nwi_mid(code);
  endfunction

endpackage

// File: rtl/nwi_timebase.sv
module nwi_timebase #(
  parameter int DIV_W = 2,
  parameter int SLOTS = 4,
  parameter int PH_W  = 3,
  parameter int SL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic [PH_W-1:0]  ph_o,
  output logic [SL_W-1:0]  slot_o,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output logic             wrap_o,
  output logic [PH_W-1:0]  ph_n_o,
  output logic [SL_W-1:0]  slot_n_o,
  output logic             run_n_o,
  output logic [DIV_W-1:0] div_n_o,
  output logic             word_clk_o,
  output logic             nib_clk_o
);
  import nwi_pkg::*;

  logic last_ph;

  always_comb begin
    last_ph  = (nwi_uint_t'(ph_o) == nwi_ratio(nwi_uint_t'(div_o)) - 1);
    wrap_o   = last_ph && (slot_o == SL_W'(SLOTS - 1));
    ph_n_o   = last_ph ? '0 : ph_o + 1'b1;
    slot_n_o = wrap_o ? '0 : (last_ph ? slot_o + 1'b1 : slot_o);
    run_n_o  = run_o | wrap_o;
    div_n_o  = wrap_o ? div_sel_i : div_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_o       <= '0;
      slot_o     <= '0;
      run_o      <= 1'b0;
      div_o      <= div_sel_i;
      word_clk_o <= 1'b0;
      nib_clk_o  <= 1'b0;
    end else begin
      ph_o       <= ph_n_o;
      slot_o     <= slot_n_o;
      run_o      <= run_n_o;
      div_o      <= div_n_o;
      word_clk_o <= run_n_o && (slot_n_o == '0);
      nib_clk_o  <= nwi_uint_t'(ph_n_o) < nwi_hi_len(nwi_uint_t'(div_n_o));
    end
  end

endmodule

// File: rtl/nwi_tx_deser.sv
module nwi_tx_deser #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 4,
  parameter int DIV_W = 2,
  parameter int PH_W  = 3,
  parameter int SL_W  = 2,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int LOW_W  = NIB_W * (SLOTS - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph_i,
  input  logic [SL_W-1:0]   slot_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wrap_i,
  input  logic              tx_rise_i,
  input  logic              lb_rx2tx_i,
  input  logic [NIB_W-1:0]  tx_nib_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_vld_o
);
  import nwi_pkg::*;

  nwi_uint_t         cap_ph;
  logic              cap;
  logic              cap_last;
  logic [LOW_W-1:0]  low_w;

  always_comb begin
    if (tx_rise_i)
      cap_ph = nwi_ratio(nwi_uint_t'(div_i)) - 1;
    else
      cap_ph = (div_i == '0) ? 0 : nwi_mid(nwi_uint_t'(div_i)) - 1;
    cap      = run_i && (nwi_uint_t'(ph_i) == cap_ph);
    cap_last = cap && (slot_i == SL_W'(SLOTS - 1));
  end

  // one holding register per lower nibble slot
  for (genvar k = 0; k < SLOTS - 1; k++) begin : g_asm
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk) begin
      if (rst)
        nib_q <= '0;
      else if (cap && (slot_i == SL_W'(k)))
        nib_q <= tx_nib_i;
    end
    assign low_w[k*NIB_W +: NIB_W] = nib_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word_o <= '0;
      tx_vld_o  <= 1'b0;
    end else begin
      tx_vld_o <= 1'b0;
      if (lb_rx2tx_i) begin
        if (wrap_i) begin
          tx_word_o <= rx_word_i;
          tx_vld_o  <= 1'b1;
        end
      end else if (cap_last) begin
        tx_word_o <= {tx_nib_i, low_w};
        tx_vld_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nwi_rx_ser.sv
module nwi_rx_ser #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 4,
  parameter int DIV_W = 2,
  parameter int PH_W  = 3,
  parameter int SL_W  = 2,
  localparam int WORD_W = NIB_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph_n_i,
  input  logic [SL_W-1:0]   slot_n_i,
  input  logic              run_n_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic              wrap_i,
  input  logic              rx_rise_i,
  input  logic [WORD_W-1:0] src_word_i,
  output logic [NIB_W-1:0]  rx_nib_o
);
  import nwi_pkg::*;

  logic [WORD_W-1:0] hold_q;
  nwi_uint_t         launch_ph;
  logic              launch;

  always_comb begin
    launch_ph = rx_rise_i ? nwi_mid(nwi_uint_t'(div_n_i)) : 0;
    launch    = run_n_i && (nwi_uint_t'(ph_n_i) == launch_ph);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      rx_nib_o <= '0;
    end else begin
      if (wrap_i)
        hold_q <= src_word_i;
      if (launch)
        rx_nib_o <= wrap_i ? src_word_i[NIB_W-1:0]
                           : hold_q[slot_n_i*NIB_W +: NIB_W];
    end
  end

endmodule

// File: rtl/nibble_word_if.sv
module nibble_word_if #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 4,
  parameter int DIV_W = 2,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int PH_W   = (1 << DIV_W) - 1,
  localparam int SL_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              tx_rise_i,
  input  logic              rx_rise_i,
  input  logic              lb_tx2rx_i,
  input  logic              lb_rx2tx_i,
  input  logic [NIB_W-1:0]  tx_nib_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              nib_clk_o,
  output logic              word_clk_o,
  output logic [NIB_W-1:0]  rx_nib_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_vld_o
);

  logic [PH_W-1:0]   ph_q, ph_n;
  logic [SL_W-1:0]   slot_q, slot_n;
  logic              run_q, run_n, wrap;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [WORD_W-1:0] ser_src;

  nwi_timebase #(.DIV_W(DIV_W), .SLOTS(SLOTS), .PH_W(PH_W), .SL_W(SL_W)) tb_i (
    .clk(clk), .rst(rst), .div_sel_i(div_sel_i),
    .ph_o(ph_q), .slot_o(slot_q), .run_o(run_q), .div_o(div_q), .wrap_o(wrap),
    .ph_n_o(ph_n), .slot_n_o(slot_n), .run_n_o(run_n), .div_n_o(div_n),
    .word_clk_o(word_clk_o), .nib_clk_o(nib_clk_o)
  );

  nwi_tx_deser #(.NIB_W(NIB_W), .SLOTS(SLOTS), .DIV_W(DIV_W), .PH_W(PH_W), .SL_W(SL_W)) tx_i (
    .clk(clk), .rst(rst), .ph_i(ph_q), .slot_i(slot_q), .run_i(run_q), .div_i(div_q),
    .wrap_i(wrap), .tx_rise_i(tx_rise_i), .lb_rx2tx_i(lb_rx2tx_i), .tx_nib_i(tx_nib_i),
    .rx_word_i(rx_word_i), .tx_word_o(tx_word_o), .tx_vld_o(tx_vld_o)
  );

  assign ser_src = lb_tx2rx_i ? tx_word_o : rx_word_i;

  nwi_rx_ser #(.NIB_W(NIB_W), .SLOTS(SLOTS), .DIV_W(DIV_W), .PH_W(PH_W), .SL_W(SL_W)) rx_i (
    .clk(clk), .rst(rst), .ph_n_i(ph_n), .slot_n_i(slot_n), .run_n_i(run_n), .div_n_i(div_n),
    .wrap_i(wrap), .rx_rise_i(rx_rise_i), .src_word_i(ser_src), .rx_nib_o(rx_nib_o)
  );

endmodule

// File: rtl/nibble_word_if_chk.sv
module nibble_word_if_chk #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             word_clk_i,
  input logic             tx_vld_i,
  input logic             lb_rx2tx_i,
  input logic [DIV_W-1:0] div_i
);
  logic             wc_d;
  logic [7:0]       per_c;
  logic [7:0]       hi_c;
  logic [DIV_W-1:0] div_w;
  logic             wc_rise;
  logic             wc_fall;

  assign wc_rise = word_clk_i && !wc_d;
  assign wc_fall = !word_clk_i && wc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_d  <= 1'b0;
      per_c <= '0;
      hi_c  <= '0;
      div_w <= div_i;
    end else begin
      wc_d  <= word_clk_i;
      per_c <= wc_rise ? 8'd1 : per_c + 8'd1;
      hi_c  <= word_clk_i ? hi_c + 8'd1 : 8'd0;
      if (wc_rise)
        div_w <= div_i;
    end
  end

  // R4 / R12: strobe period is 4N of the word that just ended (first one counted from reset)
  assert_word_period_R4: assert property (@(posedge clk) disable iff (rst)
    wc_rise |-> (per_c == (8'd4 << div_w)));

  // R4: strobe stays high N cycles
  assert_word_high_R4: assert property (@(posedge clk) disable iff (rst)
    wc_fall |-> (hi_c == (8'd1 << div_w)));

  // R8: valid is a single-cycle pulse
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tx_vld_i |=> !tx_vld_i);

  // R11: looped receive words appear only with a strobe rise
  assert_loop_frame_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_vld_i && $past(lb_rx2tx_i)) |-> wc_rise);

endmodule

bind nibble_word_if nibble_word_if_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .word_clk_i(word_clk_o), .tx_vld_i(tx_vld_o),
  .lb_rx2tx_i(lb_rx2tx_i), .div_i(div_q)
);

// File: tb/nibble_word_if_tb_top.sv
module nibble_word_if_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  div_sel;
  logic        tx_rise, rx_rise, lb_t2r, lb_r2t;
  logic [3:0]  tx_nib;
  logic [15:0] rx_word;
  logic        nib_clk, word_clk, tx_vld;
  logic [3:0]  rx_nib;
  logic [15:0] tx_word;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct { logic [15:0] w; int due; } sb_t;
  sb_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nibble_word_if dut_i (
    .clk(clk), .rst(rst), .div_sel_i(div_sel), .tx_rise_i(tx_rise), .rx_rise_i(rx_rise),
    .lb_tx2rx_i(lb_t2r), .lb_rx2tx_i(lb_r2t), .tx_nib_i(tx_nib), .rx_word_i(rx_word),
    .nib_clk_o(nib_clk), .word_clk_o(word_clk), .rx_nib_o(rx_nib),
    .tx_word_o(tx_word), .tx_vld_o(tx_vld)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = word_clk;
    forever begin
      @(negedge clk);
      if (word_clk && !p) break;
      p = word_clk;
    end
  endtask

  task automatic measure(output int n);
    logic p;
    n = 0;
    p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (word_clk && !p) break;
      p = word_clk;
    end
  endtask

  // drive one frame: w1 in first half of each slot, w2 in second half
  task automatic send_tx(input logic [15:0] w1, input logic [15:0] w2, input int n);
    logic [15:0] e;
    int cp;
    sb_t it;
    e  = (tx_rise || n == 1) ? w2 : w1;
    cp = tx_rise ? n - 1 : (n == 1 ? 0 : n / 2 - 1);
    wait_rise();
    it.w   = e;
    it.due = cyc + 3 * n + cp + 1;
    sb_q.push_back(it);
    for (int j = 0; j < 4 * n; j++) begin
      int k = j / n;
      int p = j % n;
      tx_nib = (p < n / 2) ? w1[k*4 +: 4] : w2[k*4 +: 4];
      @(negedge clk);
    end
  endtask

  // at slot cycle 0: check the nibbles of word w (R2, R7)
  task automatic rx_collect(input logic [15:0] w, input int n);
    int m;
    m = (n == 1) ? 0 : n / 2;
    for (int j = 0; j < 4 * n; j++) begin
      for (int k = 0; k < 4; k++) begin
        if (!rx_rise && j == k * n)
          chk(rx_nib == w[k*4 +: 4], "R2 R7 start launch nibble", rx_nib, w[k*4 +: 4]);
        if (rx_rise && j == k * n + m)
          chk(rx_nib == w[k*4 +: 4], "R2 R7 mid launch nibble", rx_nib, w[k*4 +: 4]);
        if (rx_rise && m >= 1 && k >= 1 && j == k * n + m - 1)
          chk(rx_nib == w[(k-1)*4 +: 4], "R7 previous nibble held to midpoint", rx_nib, w[(k-1)*4 +: 4]);
      end
      @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [15:0] w, input int n);
    rx_word = w;
    wait_rise();
    rx_word = ~w;   // R9: change after the load edge must not matter
    rx_collect(w, n);
  endtask

  // scoreboard monitor for assembled transmit words (R1, R6, R8)
  initial begin
    forever begin
      sb_t it;
      @(negedge clk);
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        it = sb_q.pop_front();
        chk(tx_vld == 1'b1, "R8 valid in due cycle", tx_vld, 1);
        chk(tx_word == it.w, "R1 R6 assembled word", tx_word, it.w);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst = 1'b1; div_sel = 2'd1; tx_rise = 0; rx_rise = 0; lb_t2r = 0; lb_r2t = 0;
    tx_nib = '0; rx_word = '0;
    repeat (3) @(negedge clk);
    chk(word_clk == 0 && nib_clk == 0, "R12 strobes low in reset", {word_clk, nib_clk}, 0);
    chk(tx_vld == 0 && rx_nib == 0, "R12 outputs low in reset", {tx_vld, rx_nib}, 0);
    rst = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!word_clk && cnt < 100);
    chk(cnt == 8, "R12 first strobe after 4N", cnt, 8);

    // N=2 transmit, both capture points
    send_tx(16'h1234, 16'hABCD, 2);
    tx_rise = 1;
    send_tx(16'h5A3C, 16'hC3A5, 2);

    // R5: change to N=4 just after a boundary
    wait_rise();
    div_sel = 2'd2;
    measure(cnt);
    chk(cnt == 8, "R5 word in progress keeps old length", cnt, 8);
    for (int j = 0; j < 16; j++) begin
      if (j == 0) ;
      chk(nib_clk == ((j % 4) < 2), "R13 R3 nibble clock N=4", nib_clk, (j % 4) < 2);
      @(negedge clk);
    end
    // now at slot cycle 0 of the next frame: period of the previous one
    chk(word_clk == 1, "R4 R3 strobe at 4N=16", word_clk, 1);

    tx_rise = 0;
    send_tx(16'h0F1E, 16'hE1F0, 4);
    tx_rise = 1;
    send_tx(16'h2468, 16'h1357, 4);
    rx_rise = 0;
    rx_frame(16'hBEEF, 4);
    rx_rise = 1;
    rx_frame(16'hCAFE, 4);

    // N=8
    div_sel = 2'd3;
    send_tx(16'h9876, 16'h4321, 8);
    measure(cnt);
    chk(cnt == 32, "R3 R4 period N=8", cnt, 32);
    rx_frame(16'h7E81, 8);

    // N=1
    div_sel = 2'd0;
    wait_rise();
    wait_rise();
    for (int j = 0; j < 4; j++) begin
      chk(nib_clk == 1, "R13 nibble clock high N=1", nib_clk, 1);
      @(negedge clk);
    end
    tx_rise = 0;
    send_tx(16'hD00D, 16'h600D, 1);
    rx_rise = 0;
    rx_frame(16'hA5A5, 1);

    // R10: transmit word looped into receive serializer
    div_sel = 2'd1;
    wait_rise();
    wait_rise();
    lb_t2r = 1; rx_word = 16'h0000; tx_rise = 0;
    send_tx(16'h3C96, 16'h3C96, 2);
    rx_collect(16'h3C96, 2);
    lb_t2r = 0;

    // R11: receive word looped into transmit output
    rx_word = 16'h6BD2;
    lb_r2t  = 1;
    wait_rise();
    chk(tx_vld == 1, "R11 loop valid at strobe rise", tx_vld, 1);
    chk(tx_word == 16'h6BD2, "R11 loop word", tx_word, 16'h6BD2);
    @(negedge clk);
    chk(tx_vld == 0, "R11 R8 loop valid one cycle", tx_vld, 0);
    lb_r2t = 0;

    wait_rise();
    wait_rise();
    chk(sb_q.size() == 0, "R8 all expected words seen", sb_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule